// File: doc/BRIEF.md
# Register-Access Idle Clock-Gate Monitor

This block watches the access strobe of one peripheral's register window and decides when that peripheral may have its clock gated. A free-running check timer, built from a tick prescaler and a programmable interval counter, fires once every threshold interval. A one-bit activity flag records whether any register access has been seen since the previous firing. When the timer fires and the flag is still clean, the monitor drops the device-enable output so a gate controller can stop the peripheral's clock.

An access to a gated peripheral raises the enable again. The access is held with a stall until a fixed wake-up delay has elapsed, and then completes normally. Software sets the interval in prescaled ticks. It should choose an interval longer than the longest quiet gap the peripheral can show while it still has work, such as a long DMA transfer. A threshold of zero, or a low monitor enable, turns automatic gating off. Address decoding, saving and restoring context, and choosing the policy are left to surrounding logic.

Top module: `idle_gate_monitor`

## Requirements
- R1: During reset and at the first cycle after reset, `devEnable` is 1, `accessStall` is 0, and the activity flag is clean.
- R2: With monitoring on and threshold N > 0, the check timer fires every N*PRESCALE clock cycles from reset release. A firing that finds the flag clean drops `devEnable` at the next clock edge, so without accesses `devEnable` goes low after exactly N*PRESCALE edges and stays low.
- R3: A firing that finds the flag set clears it and leaves `devEnable` high. A single access in the first interval therefore delays gating to exactly 2*N*PRESCALE edges.
- R4: Accesses made while the device is enabled and awake are never stalled. `accessStall` stays 0 for every cycle of such an access.
- R5: An access arriving while `devEnable` is 0 raises `accessStall` in that same cycle and raises `devEnable` at the next edge. The stall lasts WAKE_CYCLES+1 cycles in total, and the access completes on the edge that ends the first cycle with the stall low.
- R6: With threshold 0 or `monEn` low, the timer never fires and the device is never gated.
- R7: An access seen on the same edge as a timer firing wins. The device stays enabled and the flag ends up set, so gating is delayed by two more intervals.
- R8: An access that wakes the device also marks the flag set. The next firing after the wake clears the flag instead of gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| monEn | input | 1 | Automatic gating on when 1 |
| thresholdTicks | input | TW | Check interval in prescaled ticks; 0 turns gating off |
| accessValid | input | 1 | Decoded register access request, held while stalled |
| devEnable | output | 1 | 1 = peripheral clock enabled, 0 = may be gated |
| accessStall | output | 1 | 1 = current access must wait for wake-up |

## Verification
A stuck or wrongly cleared activity flag shows at the ports as `devEnable` falling one full interval too early or too late. The fault surfaces at the first timer firing after the access, so a check placed exactly on interval boundaries exposes it within two intervals. A miscounted prescaler or interval counter moves the falling edge of `devEnable` away from the exact N*PRESCALE edge. A wrong wake counter changes the length of the stall on the very access that woke the device.

// File: rtl/idlegate_pkg.sv
package idlegate_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wakeLoad;
  } ctlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic fire;
    logic wakeDone;
  } dpStatus_t;

  typedef enum logic [1:0] {
    PWR_ON     = 2'd0,
    PWR_OFF    = 2'd1,
    PWR_WAKING = 2'd2
  } pwrState_t;
endpackage

// File: rtl/idlegate_timer.sv
module idlegate_timer
  import idlegate_pkg::*;
#(
  parameter int TW          = 8,
  parameter int PRESCALE    = 8,
  parameter int WAKE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          monEn,
  input  logic [TW-1:0] thresholdTicks,
  input  ctlStrobes_t   ctl,
  output dpStatus_t     dp
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic          active;
  logic          tick;
  logic [TW-1:0] ivlCnt;
  logic [WW-1:0] wakeCnt;

  assign active = monEn && (thresholdTicks != '0);

  // tick generation: a divider when PRESCALE > 1, otherwise every cycle
  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !active)                  preCnt <= '0;
        else if (preCnt == PW'(PRESCALE - 1))  preCnt <= '0;
        else                                   preCnt <= preCnt + PW'(1);
      end
      assign tick = active && (preCnt == PW'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = active;
    end
  endgenerate

  // interval counter in ticks; >= guards a threshold lowered mid-interval
  logic lastTick;
  assign lastTick = (ivlCnt >= thresholdTicks - TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN || !active)  ivlCnt <= '0;
    else if (tick)         ivlCnt <= lastTick ? '0 : ivlCnt + TW'(1);
  end

  assign dp.fire = tick && lastTick;

  // wake-up delay counter
  always_ff @(posedge clk) begin
    if (!rstN)               wakeCnt <= '0;
    else if (ctl.wakeLoad)   wakeCnt <= WW'(WAKE_CYCLES);
    else if (wakeCnt != '0)  wakeCnt <= wakeCnt - WW'(1);
  end

  assign dp.wakeDone = (wakeCnt == WW'(1));
endmodule

// File: rtl/idlegate_ctrl.sv
module idlegate_ctrl
  import idlegate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accessValid,
  input  dpStatus_t   dp,
  output ctlStrobes_t ctl,
  output logic        devEnable,
  output logic        accessStall
);
  pwrState_t state, stateNext;
  logic      dirty, dirtyNext;

  always_comb begin
    stateNext    = state;
    ctl.wakeLoad = 1'b0;
    unique case (state)
      PWR_ON:
        if (dp.fire && !dirty && !accessValid) stateNext = PWR_OFF;
      PWR_OFF:
        if (accessValid) begin
          stateNext    = PWR_WAKING;
          ctl.wakeLoad = 1'b1;
        end
      PWR_WAKING:
        if (dp.wakeDone) stateNext = PWR_ON;
      default:
        stateNext = PWR_ON;
    endcase
  end

  // an access in the firing cycle wins over the clear
  always_comb begin
    if (accessValid)  dirtyNext = 1'b1;
    else if (dp.fire) dirtyNext = 1'b0;
    else              dirtyNext = dirty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PWR_ON;
      dirty <= 1'b0;
    end else begin
      state <= stateNext;
      dirty <= dirtyNext;
    end
  end

  assign devEnable   = (state != PWR_OFF);
  assign accessStall = accessValid && (state != PWR_ON);
endmodule

// File: rtl/idle_gate_monitor.sv
module idle_gate_monitor
  import idlegate_pkg::*;
#(
  parameter int TW          = 8,
  parameter int PRESCALE    = 8,
  parameter int WAKE_CYCLES = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          monEn,
  input  logic [TW-1:0] thresholdTicks,
  input  logic          accessValid,
  output logic          devEnable,
  output logic          accessStall
);
  ctlStrobes_t ctl;
  dpStatus_t   dp;
  logic        timerFire;

  idlegate_timer #(
    .TW(TW), .PRESCALE(PRESCALE), .WAKE_CYCLES(WAKE_CYCLES)
  ) u_timer (
    .clk(clk), .rstN(rstN), .monEn(monEn),
    .thresholdTicks(thresholdTicks), .ctl(ctl), .dp(dp)
  );

  idlegate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accessValid(accessValid), .dp(dp),
    .ctl(ctl), .devEnable(devEnable), .accessStall(accessStall)
  );

  assign timerFire = dp.fire;
endmodule

// File: rtl/idle_gate_monitor_check.sv
module idle_gate_monitor_check #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          monEn,
  input logic [TW-1:0] thresholdTicks,
  input logic          accessValid,
  input logic          devEnable,
  input logic          accessStall,
  input logic          timerFire
);
  // R2: gating only follows a timer firing
  a_r2_gate_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devEnable) |-> $past(timerFire));

  // R4: no stall without a request
  a_r4_stall_needs_access: assert property (@(posedge clk) disable iff (!rstN)
    accessStall |-> accessValid);

  // R5: an access to a gated device re-enables it on the next edge
  a_r5_wake_next_edge: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !devEnable) |=> devEnable);

  // R5: a gated device always stalls an access
  a_r5_stall_when_gated: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && !devEnable) |-> accessStall);

  // R7: an access is never followed by gating on the next edge
  a_r7_access_wins: assert property (@(posedge clk) disable iff (!rstN)
    (accessValid && devEnable) |=> devEnable);

  // R6: no firing while gating is switched off
  a_r6_off_no_fire: assert property (@(posedge clk) disable iff (!rstN)
    (thresholdTicks == '0 || !monEn) |-> !timerFire);
endmodule

bind idle_gate_monitor idle_gate_monitor_check #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .monEn(monEn), .thresholdTicks(thresholdTicks),
  .accessValid(accessValid), .devEnable(devEnable),
  .accessStall(accessStall), .timerFire(timerFire)
);

// File: tb/idle_gate_monitor_test.sv
`timescale 1ns/1ps
module idle_gate_monitor_test;
  localparam int TW = 8;
  localparam int P  = 8;
  localparam int W  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          monEn = 1'b1;
  logic [TW-1:0] thresholdTicks = TW'(3);
  logic          accessValid = 1'b0;
  logic          devEnable, accessStall;

  int vectors = 0;
  int errors  = 0;
  int edgeNo  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) edgeNo <= 0;
    else       edgeNo <= edgeNo + 1;
  end

  idle_gate_monitor #(.TW(TW), .PRESCALE(P), .WAKE_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .monEn(monEn), .thresholdTicks(thresholdTicks),
    .accessValid(accessValid), .devEnable(devEnable), .accessStall(accessStall)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, edgeNo, act, exp);
    end
  endtask

  task automatic goTo(input int n);
    while (edgeNo < n) @(negedge clk);
  endtask

  task automatic applyReset(input int thr, input logic en);
    @(negedge clk);
    rstN = 1'b0; accessValid = 1'b0;
    thresholdTicks = TW'(thr); monEn = en;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one-cycle access seen on edge n+1
  task automatic pulseAt(input int n);
    goTo(n); accessValid = 1'b1;
    @(negedge clk); accessValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 enable in reset", devEnable, 1'b1);
    check("R1 stall in reset", accessStall, 1'b0);
    applyReset(3, 1'b1);
    goTo(1);
    check("R1 enable after reset", devEnable, 1'b1);
    check("R1 stall after reset", accessStall, 1'b0);
  endtask

  task automatic testCleanGate();
    applyReset(3, 1'b1);
    goTo(23); check("R2 enabled before first fire", devEnable, 1'b1);
    goTo(24); check("R2 gated at first fire", devEnable, 1'b0);
    goTo(60); check("R2 stays gated", devEnable, 1'b0);
    check("R2 no stall idle", accessStall, 1'b0);
  endtask

  task automatic testDirtyDelay();
    applyReset(3, 1'b1);
    pulseAt(5);
    goTo(24); check("R3 dirty fire keeps enable", devEnable, 1'b1);
    goTo(47); check("R3 enabled before second fire", devEnable, 1'b1);
    goTo(48); check("R3 gated at second fire", devEnable, 1'b0);
  endtask

  task automatic testNoStallOn();
    applyReset(3, 1'b1);
    goTo(2); accessValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1 check("R4 no stall while on", accessStall, 1'b0);
      @(negedge clk);
    end
    accessValid = 1'b0;
  endtask

  task automatic testWake();
    applyReset(3, 1'b1);
    goTo(30);
    check("R5 gated before access", devEnable, 1'b0);
    accessValid = 1'b1;
    #1 check("R5 stall same cycle", accessStall, 1'b1);
    for (int k = 1; k <= W; k++) begin
      @(negedge clk);
      check("R5 enable during wake", devEnable, 1'b1);
      check("R5 stall during wake", accessStall, 1'b1);
    end
    @(negedge clk);
    check("R5 stall released", accessStall, 1'b0);
    @(negedge clk); accessValid = 1'b0;
    goTo(71); check("R8 wake access marks dirty", devEnable, 1'b1);
    goTo(72); check("R8 gated after clean interval", devEnable, 1'b0);
  endtask

  task automatic testSameCycle();
    applyReset(3, 1'b1);
    pulseAt(23);
    goTo(24); check("R7 access beats fire", devEnable, 1'b1);
    goTo(48); check("R7 flag was dirty", devEnable, 1'b1);
    goTo(71); check("R7 still enabled", devEnable, 1'b1);
    goTo(72); check("R7 gated two intervals later", devEnable, 1'b0);
  endtask

  task automatic testOff();
    applyReset(0, 1'b1);
    goTo(200); check("R6 zero threshold never gates", devEnable, 1'b1);
    applyReset(3, 1'b0);
    goTo(100); check("R6 monEn low never gates", devEnable, 1'b1);
  endtask

  task automatic testMinThreshold();
    applyReset(1, 1'b1);
    goTo(P - 1); check("R2 thr=1 enabled", devEnable, 1'b1);
    goTo(P);     check("R2 thr=1 gated at PRESCALE", devEnable, 1'b0);
  endtask

  initial begin
    testReset();
    testCleanGate();
    testDirtyDelay();
    testNoStallOn();
    testWake();
    testSameCycle();
    testOff();
    testMinThreshold();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at edge %0d: actual running expected done", edgeNo);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule